// File: doc/BRIEF.md
# Serial Port Interrupt Aggregator

This block collects four event sources of one serial port channel into a source-pending register. A mask register hides selected sources, and the pending value is the source bits that are not masked. One level-sensitive interrupt line is high whenever any pending bit is set. Software clears sources by writing ones to the pending or the source address. It programs the mask with a plain write.

The transmit source can also be raised without any event pulse. When FIFO mode is on and the transmit FIFO fill count is at or below a threshold, the block sets the transmit bit. The threshold is a 3-bit trigger field scaled by a factor that the channel-number parameter selects. The condition is checked every cycle, so the transmit bit cannot stay cleared while the FIFO remains at or below the threshold. Event generation and the FIFOs themselves sit outside this block.

Top module: `uart_irq_agg`

## Requirements
- R1: The source bits are bit 0 receive, bit 1 error, bit 2 transmit and bit 3 modem. A pulse on an event input sets its source bit on the next clock edge, and the bit then stays set until it is cleared.
- R2: Read address 0 returns pending, which equals source AND NOT mask. `irq_o` is high exactly when pending is non-zero.
- R3: A write to address 0 (pending) or address 1 (source) clears each source bit whose write-data bit is 1, and leaves the other bits unchanged.
- R4: A write to address 2 replaces the whole 4-bit mask, which reads back at address 2. The interrupt output reflects the new mask from the clock edge of the write onward.
- R5: When `fifo_en_i` is high and `tx_cnt_i` is less than or equal to the threshold, the transmit source bit is set on every clock edge. When `fifo_en_i` is low, the FIFO count has no effect.
- R6: The threshold is `tx_trig_i` times 32 for channel 0, times 8 for channels 1 and 4, and times 2 for channels 2 and 3. Any other channel gives a threshold of 0.
- R7: A pulse on `txh_wr_i` (transmit-register write completed) sets the transmit source bit.
- R8: When a set condition and a clearing write hit the same bit in the same cycle, the bit ends up set.
- R9: After reset, source, mask, pending and `irq_o` are all 0. Address 3 reads as 0, and writes to address 3 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_rx_i | input | 1 | Receive event pulse |
| evt_err_i | input | 1 | Error event pulse |
| evt_modem_i | input | 1 | Modem event pulse |
| txh_wr_i | input | 1 | Transmit-register write completed |
| fifo_en_i | input | 1 | FIFO mode enable |
| tx_trig_i | input | 3 | Transmit trigger field |
| tx_cnt_i | input | 8 | Transmit FIFO fill count |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Write address: 0 pending, 1 source, 2 mask, 3 unused |
| reg_wdata_i | input | 4 | Write data |
| rd_addr_i | input | 2 | Read address, same map as the write address |
| rd_data_o | output | 4 | Read data, combinational from the read address |
| irq_o | output | 1 | Level interrupt |

## Verification
Four copies of the block run side by side, with channels 0, 1, 2 and 5, and all of them get the same stimulus. This separates the scale factors. A FIFO count of 9 with trigger 1 fires only channel 0. A count of 8 also fires channel 1. A count of 2 also fires channel 2. A count of 0 with trigger 0 fires every channel, including the one with a zero threshold. Counts of 224 and 225 at the top trigger value test the upper edge. Single event pulses, clears through both clearing addresses, partial and full masks, a write to the unused address, and event-plus-clear collisions show whether bits are set and cleared correctly and whether set takes priority over clear.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int NSRC      = 4;
  localparam int SRC_RX    = 0;
  localparam int SRC_ERR   = 1;
  localparam int SRC_TX    = 2;
  localparam int SRC_MODEM = 3;

  typedef enum logic [1:0] {
    ADDR_PEND = 2'd0,
    ADDR_SRC  = 2'd1,
    ADDR_MASK = 2'd2,
    ADDR_RSVD = 2'd3
  } reg_addr_e;

  // left shift applied to the trigger field; -1 means threshold is zero
  function automatic int trig_shift(input int ch);
    case (ch)
      0:       return 5;
      1, 4:    return 3;
      2, 3:    return 1;
      default: return -1;
    endcase
  endfunction
endpackage

// File: rtl/uart_irq_thresh.sv
module uart_irq_thresh #(
  parameter int CHANNEL = 0,
  parameter int TRIG_W  = 3,
  parameter int CNT_W   = 8,
  parameter int THR_W   = TRIG_W + 5
) (
  input  logic              fifo_en_i,
  input  logic [TRIG_W-1:0] trig_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic [THR_W-1:0]  thr_o,
  output logic              hit_o
);
  localparam int SH    = uart_irq_pkg::trig_shift(CHANNEL);
  localparam int CMP_W = (CNT_W > THR_W) ? CNT_W : THR_W;

  logic [CMP_W-1:0] cnt_ext, thr_ext;

  generate
    if (SH < 0) begin : g_zero
      assign thr_o = '0;
    end else begin : g_scale
      logic [THR_W-1:0] trig_ext;
      assign trig_ext = {{(THR_W-TRIG_W){1'b0}}, trig_i};
      assign thr_o    = trig_ext << SH;
    end
  endgenerate

  assign cnt_ext = {{(CMP_W-CNT_W){1'b0}}, cnt_i};
  assign thr_ext = {{(CMP_W-THR_W){1'b0}}, thr_o};
  assign hit_o   = fifo_en_i && (cnt_ext <= thr_ext);
endmodule

// File: rtl/uart_irq_src.sv
module uart_irq_src #(
  parameter int NSRC = uart_irq_pkg::NSRC
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] set_i,
  input  logic [NSRC-1:0] clr_i,
  output logic [NSRC-1:0] src_o
);
  generate
    for (genvar b = 0; b < NSRC; b++) begin : g_bit
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)        src_o[b] <= 1'b0;
        else if (set_i[b])  src_o[b] <= 1'b1;  // set beats clear
        else if (clr_i[b])  src_o[b] <= 1'b0;
      end
    end
  endgenerate
endmodule

// File: rtl/uart_irq_mask.sv
module uart_irq_mask #(
  parameter int NSRC = uart_irq_pkg::NSRC
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [NSRC-1:0] wdata_i,
  input  logic [NSRC-1:0] src_i,
  output logic [NSRC-1:0] mask_o,
  output logic [NSRC-1:0] pend_o,
  output logic            irq_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   mask_o <= '0;
    else if (we_i) mask_o <= wdata_i;
  end

  assign pend_o = src_i & ~mask_o;
  assign irq_o  = |pend_o;
endmodule

// File: rtl/uart_irq_agg.sv
module uart_irq_agg #(
  parameter int CHANNEL = 0,
  parameter int TRIG_W  = 3,
  parameter int CNT_W   = 8,
  parameter int NSRC    = uart_irq_pkg::NSRC,
  parameter int THR_W   = TRIG_W + 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              evt_rx_i,
  input  logic              evt_err_i,
  input  logic              evt_modem_i,
  input  logic              txh_wr_i,
  input  logic              fifo_en_i,
  input  logic [TRIG_W-1:0] tx_trig_i,
  input  logic [CNT_W-1:0]  tx_cnt_i,
  input  logic              reg_we_i,
  input  logic [1:0]        reg_addr_i,
  input  logic [NSRC-1:0]   reg_wdata_i,
  input  logic [1:0]        rd_addr_i,
  output logic [NSRC-1:0]   rd_data_o,
  output logic              irq_o
);
  import uart_irq_pkg::*;

  logic [THR_W-1:0] thr;
  logic             lvl_hit;
  logic [NSRC-1:0]  set_v, clr_v, src_q, mask_q, pend;
  logic             mask_we;
  reg_addr_e        waddr, raddr;

  assign waddr = reg_addr_e'(reg_addr_i);
  assign raddr = reg_addr_e'(rd_addr_i);

  uart_irq_thresh #(
    .CHANNEL(CHANNEL), .TRIG_W(TRIG_W), .CNT_W(CNT_W), .THR_W(THR_W)
  ) i_thresh (
    .fifo_en_i(fifo_en_i),
    .trig_i   (tx_trig_i),
    .cnt_i    (tx_cnt_i),
    .thr_o    (thr),
    .hit_o    (lvl_hit)
  );

  always_comb begin
    set_v            = '0;
    set_v[SRC_RX]    = evt_rx_i;
    set_v[SRC_ERR]   = evt_err_i;
    set_v[SRC_TX]    = txh_wr_i | lvl_hit;
    set_v[SRC_MODEM] = evt_modem_i;
  end

  assign clr_v   = (reg_we_i && (waddr == ADDR_PEND || waddr == ADDR_SRC)) ? reg_wdata_i : '0;
  assign mask_we = reg_we_i && (waddr == ADDR_MASK);

  uart_irq_src #(.NSRC(NSRC)) i_src (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (set_v),
    .clr_i (clr_v),
    .src_o (src_q)
  );

  uart_irq_mask #(.NSRC(NSRC)) i_mask (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (mask_we),
    .wdata_i(reg_wdata_i),
    .src_i  (src_q),
    .mask_o (mask_q),
    .pend_o (pend),
    .irq_o  (irq_o)
  );

  always_comb begin
    case (raddr)
      ADDR_PEND: rd_data_o = pend;
      ADDR_SRC:  rd_data_o = src_q;
      ADDR_MASK: rd_data_o = mask_q;
      default:   rd_data_o = '0;
    endcase
  end
endmodule

// File: rtl/uart_irq_agg_chk.sv
module uart_irq_agg_chk #(
  parameter int NSRC  = 4,
  parameter int CNT_W = 8,
  parameter int THR_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             evt_rx_i,
  input logic             evt_modem_i,
  input logic             txh_wr_i,
  input logic             fifo_en_i,
  input logic [CNT_W-1:0] tx_cnt_i,
  input logic             reg_we_i,
  input logic [1:0]       reg_addr_i,
  input logic [NSRC-1:0]  reg_wdata_i,
  input logic [NSRC-1:0]  src_q,
  input logic [NSRC-1:0]  mask_q,
  input logic [THR_W-1:0] thr,
  input logic             irq_o
);
  AST_RX_ROSE_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(src_q[0]) |-> $past(evt_rx_i)); // R1

  AST_RX_UNMASKED_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_rx_i && !mask_q[0] && !(reg_we_i && reg_addr_i == 2'd2 && reg_wdata_i[0])
    |=> irq_o); // R2

  AST_MODEM_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_i && reg_addr_i == 2'd1 && reg_wdata_i[3] && !evt_modem_i |=> !src_q[3]); // R3

  AST_FULL_MASK_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&mask_q) |-> !irq_o); // R4

  AST_TX_LEVEL_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_en_i && (int'(tx_cnt_i) <= int'(thr)) |=> src_q[2]); // R5

  AST_TXH_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    txh_wr_i |=> src_q[2]); // R7

  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_rx_i && reg_we_i && reg_addr_i == 2'd0 && reg_wdata_i[0] |=> src_q[0]); // R8
endmodule

bind uart_irq_agg uart_irq_agg_chk #(
  .NSRC(NSRC), .CNT_W(CNT_W), .THR_W(THR_W)
) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .evt_rx_i   (evt_rx_i),
  .evt_modem_i(evt_modem_i),
  .txh_wr_i   (txh_wr_i),
  .fifo_en_i  (fifo_en_i),
  .tx_cnt_i   (tx_cnt_i),
  .reg_we_i   (reg_we_i),
  .reg_addr_i (reg_addr_i),
  .reg_wdata_i(reg_wdata_i),
  .src_q      (src_q),
  .mask_q     (mask_q),
  .thr        (thr),
  .irq_o      (irq_o)
);

// File: tb/test_uart_irq_agg.sv
module test_uart_irq_agg;
  localparam int CLK_PERIOD = 10;
  localparam int NDUT = 4;
  localparam int CH [NDUT] = '{0, 1, 2, 5};

  typedef struct {
    logic [3:0] rd  [NDUT];
    logic       irq [NDUT];
    string      tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic evt_rx = 0, evt_err = 0, evt_modem = 0, txh_wr = 0, fifo_en = 0;
  logic [2:0] tx_trig = '0;
  logic [7:0] tx_cnt = '0;
  logic reg_we = 0;
  logic [1:0] reg_addr = '0, rd_addr = '0;
  logic [3:0] reg_wdata = '0;
  logic [3:0] rd_data [NDUT];
  logic       irq     [NDUT];

  logic [3:0] src_m  [NDUT];
  logic [3:0] mask_m [NDUT];
  exp_t q [$];
  int n_chk = 0, n_fail = 0;
  bit drive_done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  generate
    for (genvar k = 0; k < NDUT; k++) begin : g_dut
      uart_irq_agg #(.CHANNEL(CH[k])) i_uart_irq_agg (
        .clk_i(clk), .rst_ni(rst_ni),
        .evt_rx_i(evt_rx), .evt_err_i(evt_err), .evt_modem_i(evt_modem),
        .txh_wr_i(txh_wr), .fifo_en_i(fifo_en),
        .tx_trig_i(tx_trig), .tx_cnt_i(tx_cnt),
        .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
        .rd_addr_i(rd_addr), .rd_data_o(rd_data[k]), .irq_o(irq[k])
      );
    end
  endgenerate

  function automatic int thr_of(int ch, int t);
    case (ch)
      0:       return t * 32;
      1, 4:    return t * 8;
      2, 3:    return t * 2;
      default: return 0;
    endcase
  endfunction

  task automatic apply(input logic rx, err, mdm, txh, fen, input int trig, cnt,
                       input logic we, input int wa, input logic [3:0] wd,
                       input int ra, input string tag);
    exp_t e;
    @(negedge clk);
    evt_rx = rx; evt_err = err; evt_modem = mdm; txh_wr = txh; fifo_en = fen;
    tx_trig = trig[2:0]; tx_cnt = cnt[7:0];
    reg_we = we; reg_addr = wa[1:0]; reg_wdata = wd; rd_addr = ra[1:0];
    for (int k = 0; k < NDUT; k++) begin
      logic [3:0] set_b, clr_b, pend;
      logic hit;
      hit   = fen && (cnt <= thr_of(CH[k], trig));
      set_b = {mdm, txh | hit, err, rx};
      clr_b = (we && (wa == 0 || wa == 1)) ? wd : 4'b0;
      src_m[k] = (src_m[k] & ~clr_b) | set_b;
      if (we && wa == 2) mask_m[k] = wd;
      pend = src_m[k] & ~mask_m[k];
      case (ra)
        0: e.rd[k] = pend;
        1: e.rd[k] = src_m[k];
        2: e.rd[k] = mask_m[k];
        default: e.rd[k] = 4'b0;
      endcase
      e.irq[k] = |pend;
    end
    e.tag = tag;
    q.push_back(e);
  endtask

  task automatic idle(input int ra, input string tag);
    apply(0, 0, 0, 0, 0, 0, 0, 0, 0, 4'h0, ra, tag);
  endtask

  task automatic wr(input int wa, input logic [3:0] wd, input int ra, input string tag);
    apply(0, 0, 0, 0, 0, 0, 0, 1, wa, wd, ra, tag);
  endtask

  task automatic lvl(input logic fen, input int trig, cnt, input string tag);
    apply(0, 0, 0, 0, fen, trig, cnt, 0, 0, 4'h0, 1, tag);
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #(CLK_PERIOD/4);
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        for (int k = 0; k < NDUT; k++) begin
          n_chk++;
          if (rd_data[k] !== e.rd[k]) begin
            n_fail++;
            $display("FAIL %s ch%0d rd_data actual=%b expected=%b", e.tag, CH[k], rd_data[k], e.rd[k]);
          end
          n_chk++;
          if (irq[k] !== e.irq[k]) begin
            n_fail++;
            $display("FAIL %s ch%0d irq actual=%b expected=%b", e.tag, CH[k], irq[k], e.irq[k]);
          end
        end
      end
    end
  end

  // driver
  initial begin
    for (int k = 0; k < NDUT; k++) begin src_m[k] = '0; mask_m[k] = '0; end
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    // R9 reset state
    idle(0, "R9"); idle(1, "R9"); idle(2, "R9"); idle(3, "R9");
    // R1 single events
    apply(1, 0, 0, 0, 0, 0, 0, 0, 0, 4'h0, 0, "R1");
    apply(0, 1, 0, 0, 0, 0, 0, 0, 0, 4'h0, 1, "R1");
    apply(0, 0, 1, 0, 0, 0, 0, 0, 0, 4'h0, 1, "R1");
    idle(0, "R2");
    // R3 clears through both addresses
    wr(0, 4'b0001, 1, "R3");
    wr(1, 4'b1000, 0, "R3");
    // R4 partial mask
    wr(2, 4'b0010, 0, "R4");
    idle(2, "R4");
    // R9 unused address
    wr(3, 4'b1111, 3, "R9");
    idle(1, "R9"); idle(2, "R9");
    wr(2, 4'b0000, 0, "R4");
    wr(1, 4'b1111, 1, "R3");
    // R7 transmit write
    apply(0, 0, 0, 1, 0, 0, 0, 0, 0, 4'h0, 1, "R7");
    wr(0, 4'b0100, 0, "R3");
    // R8 set wins over clear
    apply(1, 0, 0, 0, 0, 0, 0, 1, 0, 4'b0001, 1, "R8");
    apply(0, 0, 1, 0, 0, 0, 0, 1, 1, 4'b1000, 1, "R8");
    wr(1, 4'b1111, 1, "R3");
    // R5/R6 level trigger and channel scaling
    lvl(0, 1, 0, "R5");
    lvl(1, 1, 9, "R6");
    wr(1, 4'b0100, 1, "R5");
    lvl(1, 1, 8, "R6");
    wr(1, 4'b0100, 1, "R5");
    lvl(1, 1, 2, "R6");
    wr(1, 4'b0100, 1, "R5");
    lvl(1, 1, 3, "R6");
    wr(1, 4'b0100, 1, "R5");
    lvl(1, 0, 0, "R6");
    apply(0, 0, 0, 0, 1, 0, 0, 1, 1, 4'b0100, 1, "R8");
    wr(1, 4'b0100, 1, "R5");
    lvl(0, 0, 0, "R5");
    lvl(1, 7, 225, "R6");
    lvl(1, 7, 224, "R6");
    wr(1, 4'b0100, 1, "R5");
    lvl(1, 7, 57, "R6");
    wr(1, 4'b0100, 1, "R5");
    // R4 full mask then unmask
    wr(2, 4'b1111, 2, "R4");
    apply(1, 1, 1, 1, 0, 0, 0, 0, 0, 4'h0, 0, "R4");
    wr(2, 4'b0000, 0, "R4");
    wr(0, 4'b1111, 0, "R3");
    idle(0, "R2");
    idle(0, "R2");
    drive_done = 1;
  end

  // completion and watchdog
  initial begin
    fork
      begin
        wait (drive_done && q.size() == 0);
        repeat (2) @(posedge clk);
      end
      begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
      end
    join_any
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule